// File: doc/BRIEF.md
# Two-Bank Interrupt Service Engine

The engine gathers single-cycle event pulses into two pending-status banks of `BANK_W` bits each. Each bank has its own mask, and the engine drives one interrupt request line. Sources are switched on and off by a command port. Turning a source on clears its mask bit, and turning it off sets the bit again. The host can read either status bank or either mask bank through a small register port. A write to a status address clears the status bits written as one.

When the request line is high and the engine is idle, a built-in sequencer starts a service pass. It drops the request line at once and copies the enabled pending bits of both banks. In the next cycle it clears exactly those bits in the status banks. In that same cycle it re-arms the request line, so any later event raises a fresh request. The sequencer then walks a constant priority table. Each table entry names one source, and the pass presents the table index of every serviced source on a valid/ready output, one at a time. The pass ends as soon as nothing remains in the copy.

The event output follows valid/ready rules. While `evt_valid_o` is high and `evt_ready_i` is low, the index is held and the walk does not move. The transfer completes on the rising edge where both are high. The consumer may hold ready low for any number of cycles.

Top module: `isr2_engine`

## Requirements
- R1: After reset, both mask banks read as all ones, both status banks read zero, `irq_o` is low and `evt_valid_o` is low.
- R2: A one on `evt0_i[b]` or `evt1_i[b]` sets status bit b of bank 0 or bank 1 on the next edge. The bit stays set until cleared. The register port reads status bank 0 at address 0, status bank 1 at address 1, mask bank 0 at address 2 and mask bank 1 at address 3.
- R3: A register write to address 0 or 1 clears every status bit of that bank whose write-data bit is one. An event pulse on the same bit in the same cycle wins, and the bit stays set.
- R4: A source command carries a 6-bit id. Bit 5 selects the bank and bits 4:0 select the bit. A command with enable high clears that mask bit, and a command with enable low sets it. An id whose bit field is `BANK_W` or more changes nothing.
- R5: `irq_o` is high only when the line is armed and at least one status bit is set while its mask bit is clear. Pending bits whose mask is set never raise it.
- R6: The cycle after `irq_o` is seen high by an idle sequencer, `irq_o` is low. It stays low until the acknowledge cycle is over.
- R7: A service pass clears only the status bits that were pending and still enabled. Pending bits whose mask is set are left unchanged.
- R8: Serviced sources are presented in ascending table index order, and `evt_index_o` carries the table index. Entry i names source k = (i*`TBL_STRIDE`) mod (2*`BANK_W`). That source sits in bank k/`BANK_W` at bit k mod `BANK_W`.
- R9: While `evt_valid_o` is high and `evt_ready_i` is low, `evt_valid_o` stays high and `evt_index_o` holds its value.
- R10: The walk stops on the handshake of the last serviced source. A request pending at that point is taken on the following edge, so `irq_o` falls within two cycles of that handshake.
- R11: An enabled event that arrives after the acknowledge cycle raises `irq_o` again while the current pass is still running. It is then serviced by a second pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt0_i | input | BANK_W | Event pulses for bank 0 |
| evt1_i | input | BANK_W | Event pulses for bank 1 |
| src_cmd_valid_i | input | 1 | Source enable/disable command strobe |
| src_cmd_id_i | input | 6 | Source id: bit 5 bank, bits 4:0 bit |
| src_cmd_en_i | input | 1 | 1 enables (unmasks), 0 disables (masks) |
| reg_wr_i | input | 1 | Register write strobe (status clear) |
| reg_addr_i | input | 2 | Register address 0..3 |
| reg_wdata_i | input | BANK_W | Write-one-to-clear data |
| reg_rdata_o | output | BANK_W | Read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request |
| evt_valid_o | output | 1 | Serviced event index is valid |
| evt_ready_i | input | 1 | Consumer accepts the index |
| evt_index_o | output | IDX_W | Table index of the serviced source |

## Verification
The table order is checked in two ways. A sweep enables each of the 48 sources alone, which shows that every source maps to the right table index and is cleared. Wide patterns (all bits, alternating bits in each bank) show that a pass presents many hits in strict ascending order and then stops. A mix of enabled and disabled pending bits separates clearing by mask from clearing everything, and a same-cycle event-plus-clear shows which side wins. A held-ready run and a pulse that arrives mid-walk separate true back-pressure, early stop and re-raising from a pass that finishes the whole table regardless.

// File: rtl/isr2_pkg.sv
package isr2_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ACK  = 2'd1,
    S_WALK = 2'd2
  } seq_st_e;

  // Table entry i -> source id (bank in bit 5, bit position in bits 4:0)
  function automatic logic [5:0] tbl_src(input int i, input int stride,
                                         input int nsrc, input int bw);
    int k;
    k = (i * stride) % nsrc;
    return 6'(((k / bw) * 32) + (k % bw));
  endfunction

endpackage

// File: rtl/isr2_bank.sv
module isr2_bank #(
  parameter int BW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] evt_i,
  input  logic [BW-1:0] clr_i,
  input  logic          cmd_we_i,
  input  logic [4:0]    cmd_bit_i,
  input  logic          cmd_en_i,
  output logic [BW-1:0] status_o,
  output logic [BW-1:0] mask_o
);

  logic [BW-1:0] status_q;
  logic [BW-1:0] mask_q;

  // New pulses override a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_i) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (cmd_we_i) begin
      for (int b = 0; b < BW; b++) begin
        if (cmd_bit_i == 5'(b)) mask_q[b] <= ~cmd_en_i;
      end
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;

endmodule

// File: rtl/isr2_seq.sv
module isr2_seq
  import isr2_pkg::*;
#(
  parameter int BW = 24,
  parameter int TL = 48,
  parameter int TS = 1,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [BW-1:0] en0_i,
  input  logic [BW-1:0] en1_i,
  input  logic [BW-1:0] pend0_i,
  input  logic [BW-1:0] pend1_i,
  input  logic          evt_ready_i,
  output logic          arm_o,
  output logic          busy_o,
  output logic [BW-1:0] ack0_o,
  output logic [BW-1:0] ack1_o,
  output logic          evt_valid_o,
  output logic [IW-1:0] evt_index_o
);

  localparam int NS = 2 * BW;

  seq_st_e       st_q;
  logic [IW-1:0] idx_q;
  logic [BW-1:0] snap0_q, snap1_q;
  logic          arm_q;

  logic [5:0] tbl [TL];
  generate
    for (genvar i = 0; i < TL; i++) begin : g_tbl
      assign tbl[i] = tbl_src(i, TS, NS, BW);
    end
  endgenerate

  logic [5:0]    cur;
  logic [31:0]   sel32;
  logic [BW-1:0] sel0, sel1;
  logic          hit, left, last;

  always_comb begin
    cur   = tbl[idx_q];
    sel32 = 32'd1 << cur[4:0];
    sel0  = cur[5] ? '0 : sel32[BW-1:0];
    sel1  = cur[5] ? sel32[BW-1:0] : '0;
    hit   = |((snap0_q & sel0) | (snap1_q & sel1));
    left  = |((snap0_q & ~sel0) | (snap1_q & ~sel1));
    last  = (idx_q == IW'(TL - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      idx_q   <= '0;
      snap0_q <= '0;
      snap1_q <= '0;
      arm_q   <= 1'b1;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (req_i) begin
            snap0_q <= pend0_i;
            snap1_q <= pend1_i;
            arm_q   <= 1'b0;
            st_q    <= S_ACK;
          end
        end
        S_ACK: begin
          snap0_q <= snap0_q & en0_i;
          snap1_q <= snap1_q & en1_i;
          arm_q   <= 1'b1;
          idx_q   <= '0;
          st_q    <= (|(snap0_q & en0_i) || |(snap1_q & en1_i)) ? S_WALK : S_IDLE;
        end
        S_WALK: begin
          if (hit) begin
            if (evt_ready_i) begin
              snap0_q <= snap0_q & ~sel0;
              snap1_q <= snap1_q & ~sel1;
              if (!left || last) st_q <= S_IDLE;
              else               idx_q <= idx_q + 1'b1;
            end
          end else if (last) begin
            st_q <= S_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign arm_o       = arm_q;
  assign busy_o      = (st_q != S_IDLE);
  assign ack0_o      = (st_q == S_ACK) ? (snap0_q & en0_i) : '0;
  assign ack1_o      = (st_q == S_ACK) ? (snap1_q & en1_i) : '0;
  assign evt_valid_o = (st_q == S_WALK) && hit;
  assign evt_index_o = idx_q;

endmodule

// File: rtl/isr2_engine.sv
module isr2_engine #(
  parameter int BANK_W     = 24,
  parameter int TBL_LEN    = 48,
  parameter int TBL_STRIDE = 1,
  localparam int IDX_W     = (TBL_LEN > 1) ? $clog2(TBL_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] evt0_i,
  input  logic [BANK_W-1:0] evt1_i,
  input  logic              src_cmd_valid_i,
  input  logic [5:0]        src_cmd_id_i,
  input  logic              src_cmd_en_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [BANK_W-1:0] reg_wdata_i,
  output logic [BANK_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              evt_valid_o,
  input  logic              evt_ready_i,
  output logic [IDX_W-1:0]  evt_index_o
);

  logic [BANK_W-1:0] st   [2];
  logic [BANK_W-1:0] mk   [2];
  logic [BANK_W-1:0] ack  [2];
  logic [BANK_W-1:0] hclr [2];
  logic [BANK_W-1:0] evt  [2];
  logic              cmd_ok;
  logic              arm, busy;

  assign evt[0] = evt0_i;
  assign evt[1] = evt1_i;
  assign cmd_ok = src_cmd_valid_i && (int'(src_cmd_id_i[4:0]) < BANK_W);

  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      assign hclr[b] = (reg_wr_i && reg_addr_i == 2'(b)) ? reg_wdata_i : '0;
      isr2_bank #(.BW(BANK_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt[b]),
        .clr_i     (hclr[b] | ack[b]),
        .cmd_we_i  (cmd_ok && (src_cmd_id_i[5] == 1'(b))),
        .cmd_bit_i (src_cmd_id_i[4:0]),
        .cmd_en_i  (src_cmd_en_i),
        .status_o  (st[b]),
        .mask_o    (mk[b])
      );
    end
  endgenerate

  assign irq_o = arm && (|(st[0] & ~mk[0]) || |(st[1] & ~mk[1]));

  isr2_seq #(.BW(BANK_W), .TL(TBL_LEN), .TS(TBL_STRIDE), .IW(IDX_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (irq_o),
    .en0_i       (~mk[0]),
    .en1_i       (~mk[1]),
    .pend0_i     (st[0] & ~mk[0]),
    .pend1_i     (st[1] & ~mk[1]),
    .evt_ready_i (evt_ready_i),
    .arm_o       (arm),
    .busy_o      (busy),
    .ack0_o      (ack[0]),
    .ack1_o      (ack[1]),
    .evt_valid_o (evt_valid_o),
    .evt_index_o (evt_index_o)
  );

  always_comb begin
    case (reg_addr_i)
      2'd0:    reg_rdata_o = st[0];
      2'd1:    reg_rdata_o = st[1];
      2'd2:    reg_rdata_o = mk[0];
      default: reg_rdata_o = mk[1];
    endcase
  end

endmodule

// File: rtl/isr2_chk.sv
module isr2_chk #(
  parameter int BW = 24,
  parameter int TL = 48,
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          busy,
  input logic          evt_valid,
  input logic          evt_ready,
  input logic [IW-1:0] evt_index,
  input logic [BW-1:0] evt0,
  input logic [BW-1:0] evt1,
  input logic [BW-1:0] st0,
  input logic [BW-1:0] st1,
  input logic [BW-1:0] mk0,
  input logic [BW-1:0] mk1,
  input logic [BW-1:0] hclr0,
  input logic [BW-1:0] hclr1
);

  // R6
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !busy) |=> !irq);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_index)));

  // R3
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(evt0) & ~st0) == '0) && (($past(evt1) & ~st1) == '0)));

  // R7
  keep_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(st0 & mk0 & ~hclr0) & ~st0) == '0) &&
              (($past(st1 & mk1 & ~hclr1) & ~st1) == '0)));

  // R8
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (int'(evt_index) < TL));

  // R5
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((st0 & ~mk0) == '0) && ((st1 & ~mk1) == '0)) |-> !irq);

endmodule

bind isr2_engine isr2_chk #(.BW(BANK_W), .TL(TBL_LEN), .IW(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq_o),
  .busy      (busy),
  .evt_valid (evt_valid_o),
  .evt_ready (evt_ready_i),
  .evt_index (evt_index_o),
  .evt0      (evt0_i),
  .evt1      (evt1_i),
  .st0       (st[0]),
  .st1       (st[1]),
  .mk0       (mk[0]),
  .mk1       (mk[1]),
  .hclr0     (hclr[0]),
  .hclr1     (hclr[1])
);

// File: tb/isr2_engine_tb.sv
`timescale 1ns/1ps
module isr2_engine_tb;

  localparam int BW = 24;
  localparam int TL = 48;
  localparam int TS = 5;
  localparam int NS = 2 * BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [BW-1:0] evt0 = '0, evt1 = '0;
  logic          cmd_v = 1'b0, cmd_en = 1'b0;
  logic [5:0]    cmd_id = '0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [BW-1:0] reg_wdata = '0, reg_rdata;
  logic          irq, evt_valid, evt_ready = 1'b0;
  logic [5:0]    evt_index;

  int nchk = 0, nfail = 0;
  bit done = 0;
  int got[$];
  int exp_q[$];

  always #2.5 clk = ~clk;

  isr2_engine #(.BANK_W(BW), .TBL_LEN(TL), .TBL_STRIDE(TS)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt0_i(evt0), .evt1_i(evt1),
    .src_cmd_valid_i(cmd_v), .src_cmd_id_i(cmd_id), .src_cmd_en_i(cmd_en),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq), .evt_valid_o(evt_valid),
    .evt_ready_i(evt_ready), .evt_index_o(evt_index)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [BW-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic w1c(input logic [1:0] a, input logic [BW-1:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic cmd(input logic [5:0] id, input logic en);
    @(negedge clk); cmd_v = 1; cmd_id = id; cmd_en = en;
    @(negedge clk); cmd_v = 0;
  endtask

  task automatic pulse(input logic [BW-1:0] b0, input logic [BW-1:0] b1);
    @(negedge clk); evt0 = b0; evt1 = b1;
    @(negedge clk); evt0 = '0; evt1 = '0;
  endtask

  function automatic logic [5:0] src_id(input int k);
    return 6'(((k / BW) * 32) + (k % BW));
  endfunction

  function automatic int tbl_k(input int i);
    return (i * TS) % NS;
  endfunction

  // Expected order for pending pattern p0/p1 restricted to enables e0/e1 (R8)
  task automatic build_exp(input logic [BW-1:0] p0, input logic [BW-1:0] p1,
                           input logic [BW-1:0] e0, input logic [BW-1:0] e1);
    exp_q.delete();
    for (int i = 0; i < TL; i++) begin
      int k;
      k = tbl_k(i);
      if (k < BW) begin
        if (p0[k] && e0[k]) exp_q.push_back(i);
      end else begin
        if (p1[k-BW] && e1[k-BW]) exp_q.push_back(i);
      end
    end
  endtask

  // Collect one or more passes; hold ready low for 'hold' cycles per event
  task automatic run_service(input int hold);
    int idle, waitc;
    logic [5:0] held;
    got.delete();
    idle = 0; waitc = 0; held = '0;
    while (idle < 70) begin
      @(negedge clk);
      if (evt_valid) begin
        idle = 0;
        if (waitc > 0) chk(evt_index == held, "R9 held index", evt_index, held);
        if (waitc < hold) begin
          evt_ready = 0; held = evt_index; waitc++;
        end else begin
          evt_ready = 1; got.push_back(int'(evt_index)); waitc = 0;
        end
      end else begin
        evt_ready = 0;
        idle++;
      end
    end
    evt_ready = 0;
  endtask

  task automatic cmp_got(input string req);
    chk(got.size() == exp_q.size(), req, got.size(), exp_q.size());
    if (got.size() == exp_q.size())
      for (int j = 0; j < got.size(); j++)
        chk(got[j] == exp_q[j], req, got[j], exp_q[j]);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(2, d); chk(d == '1, "R1 mask0", d, 24'hFFFFFF);
    rd(3, d); chk(d == '1, "R1 mask1", d, 24'hFFFFFF);
    rd(0, d); chk(d == '0, "R1 status0", d, 0);
    rd(1, d); chk(d == '0, "R1 status1", d, 0);
    chk(!irq && !evt_valid, "R1 outputs idle", {irq, evt_valid}, 0);

    // R2 / R5: masked pulses are recorded, no request
    pulse(24'h00A005, 24'h800001);
    rd(0, d); chk(d == 24'h00A005, "R2 status0 sticky", d, 24'h00A005);
    rd(1, d); chk(d == 24'h800001, "R2 status1 sticky", d, 24'h800001);
    chk(!irq, "R5 masked pending quiet", irq, 0);

    // R3: clear and same-cycle event
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = 24'h000005; evt0 = 24'h000004;
    @(negedge clk); reg_wr = 0; evt0 = '0;
    rd(0, d); chk(d == 24'h00A004, "R3 event wins over clear", d, 24'h00A004);
    w1c(0, '1); w1c(1, '1);
    rd(0, d); chk(d == '0, "R3 clear bank0", d, 0);
    rd(1, d); chk(d == '0, "R3 clear bank1", d, 0);

    // R4: enable/disable and out-of-range id
    cmd(6'd30, 1);
    rd(2, d); chk(d == '1, "R4 out-of-range ignored", d, 24'hFFFFFF);
    cmd(6'd33, 1);
    rd(3, d); chk(d == 24'hFFFFFD, "R4 enable clears mask", d, 24'hFFFFFD);
    cmd(6'd33, 0);
    rd(3, d); chk(d == '1, "R4 disable sets mask", d, 24'hFFFFFF);

    // R7 / R6: mix of enabled and disabled pending bits
    cmd(6'd1, 1); cmd(6'd34, 1);
    @(negedge clk); evt0 = 24'h000012; evt1 = 24'h000084;
    @(negedge clk); evt0 = '0; evt1 = '0;
    chk(irq, "R5 enabled pending raises", irq, 1);
    @(negedge clk);
    chk(!irq, "R6 request dropped on start", irq, 0);
    build_exp(24'h000012, 24'h000084, 24'h000002, 24'h000004);
    run_service(0);
    cmp_got("R8 mixed order");
    rd(0, d); chk(d == 24'h000010, "R7 disabled bit kept bank0", d, 24'h000010);
    rd(1, d); chk(d == 24'h000080, "R7 disabled bit kept bank1", d, 24'h000080);
    cmd(6'd1, 0); cmd(6'd34, 0);
    w1c(0, '1); w1c(1, '1);

    // R8 / R7: single-source sweep over all sources
    for (int k = 0; k < NS; k++) begin
      int idx;
      idx = -1;
      for (int i = 0; i < TL; i++) if (tbl_k(i) == k) idx = i;
      cmd(src_id(k), 1);
      if (k < BW) pulse(BW'(1) << k, '0); else pulse('0, BW'(1) << (k - BW));
      run_service(0);
      chk(got.size() == 1 && got[0] == idx, "R8 single source index",
          (got.size() == 1) ? got[0] : -1, idx);
      rd(k < BW ? 2'd0 : 2'd1, d); chk(d == '0, "R7 serviced bit cleared", d, 0);
      cmd(src_id(k), 0);
    end

    // R8 / R9: all enabled, several patterns, with back-pressure
    for (int k = 0; k < NS; k++) cmd(src_id(k), 1);
    pulse('1, '1);
    build_exp('1, '1, '1, '1);
    run_service(0);
    cmp_got("R8 all pending");
    pulse(24'h555555, 24'hAAAAAA);
    build_exp(24'h555555, 24'hAAAAAA, '1, '1);
    run_service(2);
    cmp_got("R9 back-pressure order");
    pulse(24'h800000, 24'h000001);
    build_exp(24'h800000, 24'h000001, '1, '1);
    run_service(3);
    cmp_got("R8 edge bits");
    for (int k = 0; k < NS; k++) cmd(src_id(k), 0);

    // R10 / R11: early stop and re-raise during a pass
    cmd(src_id(tbl_k(0)), 1); cmd(src_id(tbl_k(1)), 1);
    pulse(24'h000001, '0);
    for (int t = 0; t < 10 && !evt_valid; t++) @(negedge clk);
    chk(evt_valid && evt_index == 0, "R8 first index", evt_index, 0);
    pulse(BW'(1) << tbl_k(1), '0);
    chk(irq, "R11 re-raised during pass", irq, 1);
    chk(evt_valid && evt_index == 0, "R9 held while not ready", evt_index, 0);
    evt_ready = 1;
    @(negedge clk); evt_ready = 0;
    chk(!evt_valid && irq, "R10 pass ended, request pending", {evt_valid, irq}, 2'b01);
    @(negedge clk);
    chk(!irq, "R10 new pass taken at once", irq, 0);
    exp_q.delete(); exp_q.push_back(1);
    run_service(0);
    cmp_got("R11 second pass");
    rd(0, d); chk(d == '0, "R7 both cleared", d, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

endmodule